// File: doc/BRIEF.md
# Vibration Phase Search Controller

This block decides how far a reference clock has to be delayed, and whether it has to be inverted, so that energy-conversion cycles line up with the motion of a vibrating capacitor. An external measurement path reports a harvested-energy count, with a valid strobe, for each delay setting in turn. The controller sweeps its delay code from zero up to a stored calibration code with the clock passed straight through. It then sets an inversion output and sweeps the same range again. It keeps the strongest count seen in each sweep, along with the code where it occurred, and finally selects the better of the two sweeps.

The sweep uses a large step wherever the energy is poor and a unit step elsewhere, which keeps the search short. Once locked, the block holds its code and looks at only every Nth energy count. When one of these sampled counts falls below a fraction of the stored best, a fresh search begins. Choosing the best count over the entire period means that local peaks, for example from distorted plate motion, do not capture the result.

Top module: `vib_phase_seek`

## Requirements
- R1: After reset, delayCode is 0, invPol is 0 and locked is 0. A start pulse, sampled on a clock edge, begins a search at code 0 with invPol 0 from the next cycle.
- R2: The first sweep runs with invPol 0. When it ends, invPol becomes 1 and delayCode returns to 0 for the second sweep, on the edge that accepts the last count of the first sweep.
- R3: At the end of the second sweep, the block outputs the code and polarity of the larger sweep maximum. If the two maxima are equal, the direct polarity (invPol 0) is chosen.
- R4: Each accepted count during a sweep moves delayCode forward. The step is coarseStep when the count is below lowThresh and 1 otherwise.
- R5: A sweep ends with the count taken at the last code for which code plus step would exceed calCode. calCode itself is tried only when a step lands on it.
- R6: Within a sweep, a count replaces the recorded maximum only if it is strictly larger. An equal count keeps the earlier code, and a smaller local peak after the global one has no effect.
- R7: While locked, delayCode and invPol stay constant. Only every SUB_RATE-th valid count (default 4) is compared, and all other counts have no effect.
- R8: The relock bound is max - (max >> relockShift), where max is the stored winning count. A compared count strictly below the bound clears locked and restarts the search at code 0 with invPol 0. A count equal to the bound holds the lock.
- R9: locked is 0 for the whole of a search and becomes 1 on the edge that accepts the final count of the second sweep.
- R10: A start pulse restarts the search from any state, including in the middle of a sweep or while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new search |
| calCode | input | CODE_W | Largest code of a half-period sweep |
| lowThresh | input | CNT_W | Counts below this use the coarse step |
| coarseStep | input | CODE_W | Step size in low-energy regions |
| relockShift | input | SHIFT_W | Shift that sets the relock bound |
| energyCount | input | CNT_W | Harvested-energy count |
| energyValid | input | 1 | energyCount is valid this cycle |
| delayCode | output | CODE_W | Current or locked delay code |
| invPol | output | 1 | Reference clock is inverted |
| locked | output | 1 | Search finished and lock held |

## Verification
A wrong step or a wrong end-of-sweep decision appears at delayCode on the cycle after the offending count, because each accepted count updates the code on a single edge. A corrupted sweep maximum or a wrong tie rule stays hidden until the second sweep finishes, and then shows as the wrong locked code or polarity. A wrong subsample counter or relock bound shows only after locking, as a restart that comes too early or too late within a group of SUB_RATE counts. For that reason the stimulus places its bound-equal and bound-minus-one counts exactly on the compared positions.

// File: rtl/vib_phase_pkg.sv
package vib_phase_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEARCH, ST_LOCK} seekState_t;

  typedef struct packed {
    logic clear;
    logic step;
    logic flip;
    logic commit;
  } dpStrobe_t;
endpackage

// File: rtl/vib_phase_dp.sv
module vib_phase_dp
  import vib_phase_pkg::*;
#(
  parameter int CODE_W  = 8,
  parameter int CNT_W   = 16,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dpStrobe_t          st,
  input  logic [CODE_W-1:0]  calCode,
  input  logic [CNT_W-1:0]   lowThresh,
  input  logic [CODE_W-1:0]  coarseStep,
  input  logic [SHIFT_W-1:0] relockShift,
  input  logic [CNT_W-1:0]   energyCount,
  output logic               sweepEnd,
  output logic               belowBound,
  output logic [CODE_W-1:0]  delayCode,
  output logic               invPol
);
  localparam int SUM_W = CODE_W + 1;

  logic [CNT_W-1:0]  curBestCnt, p0Cnt, storedMax;
  logic [CODE_W-1:0] curBestCode, p0Code;
  logic [CNT_W-1:0]  candCnt, bound;
  logic [CODE_W-1:0] candCode, stepAmt;
  logic [SUM_W-1:0]  nextSum;
  logic              better;

  always_comb begin
    better     = energyCount > curBestCnt;
    candCnt    = better ? energyCount : curBestCnt;
    candCode   = better ? delayCode : curBestCode;
    stepAmt    = (energyCount < lowThresh) ? coarseStep : CODE_W'(1);
    nextSum    = {1'b0, delayCode} + {1'b0, stepAmt};
    sweepEnd   = nextSum > {1'b0, calCode};
    bound      = storedMax - (storedMax >> relockShift);
    belowBound = energyCount < bound;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curBestCnt  <= '0;
      curBestCode <= '0;
      p0Cnt       <= '0;
      p0Code      <= '0;
      storedMax   <= '0;
      delayCode   <= '0;
      invPol      <= 1'b0;
    end else if (st.clear) begin
      curBestCnt  <= '0;
      curBestCode <= '0;
      p0Cnt       <= '0;
      p0Code      <= '0;
      delayCode   <= '0;
      invPol      <= 1'b0;
    end else if (st.step) begin
      curBestCnt  <= candCnt;
      curBestCode <= candCode;
      delayCode   <= nextSum[CODE_W-1:0];
    end else if (st.flip) begin
      p0Cnt       <= candCnt;
      p0Code      <= candCode;
      curBestCnt  <= '0;
      curBestCode <= '0;
      delayCode   <= '0;
      invPol      <= 1'b1;
    end else if (st.commit) begin
      if (candCnt > p0Cnt) begin
        delayCode <= candCode;
        invPol    <= 1'b1;
        storedMax <= candCnt;
      end else begin
        delayCode <= p0Code;
        invPol    <= 1'b0;
        storedMax <= p0Cnt;
      end
    end
  end

  // R2
  flip_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.flip |=> (invPol && delayCode == '0));
  // R4
  step_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.step |=> delayCode > $past(delayCode));
  // R5
  step_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.step |=> delayCode <= $past(calCode));
  // R3
  commit_best_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.commit |=> storedMax >= $past(p0Cnt));
  // R7
  hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == '0) |=> ($stable(delayCode) && $stable(invPol)));
endmodule

// File: rtl/vib_phase_ctrl.sv
module vib_phase_ctrl
  import vib_phase_pkg::*;
#(
  parameter int SUB_RATE = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      energyValid,
  input  logic      sweepEnd,
  input  logic      belowBound,
  input  logic      invPol,
  output dpStrobe_t st,
  output logic      locked
);
  localparam int SUB_W = $clog2(SUB_RATE) + 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_RATE - 1);

  seekState_t       state;
  logic [SUB_W-1:0] subCnt;
  logic             subHit;

  assign subHit = energyValid && (subCnt == SUB_LAST);

  always_comb begin
    st = '0;
    if (start) begin
      st.clear = 1'b1;
    end else begin
      case (state)
        ST_SEARCH:
          if (energyValid) begin
            if (!sweepEnd)    st.step   = 1'b1;
            else if (!invPol) st.flip   = 1'b1;
            else              st.commit = 1'b1;
          end
        ST_LOCK:
          if (subHit && belowBound) st.clear = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      locked <= 1'b0;
      subCnt <= '0;
    end else if (st.clear) begin
      state  <= ST_SEARCH;
      locked <= 1'b0;
      subCnt <= '0;
    end else if (st.commit) begin
      state  <= ST_LOCK;
      locked <= 1'b1;
      subCnt <= '0;
    end else if (state == ST_LOCK && energyValid) begin
      subCnt <= subHit ? '0 : subCnt + 1'b1;
    end
  end

  // R9
  search_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEARCH) |-> !locked);
  // R10
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state == ST_SEARCH && !locked));
  // R2
  commit_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st.commit |-> invPol);
  // R7
  sub_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    subCnt <= SUB_LAST);
endmodule

// File: rtl/vib_phase_seek.sv
module vib_phase_seek
  import vib_phase_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int CNT_W    = 16,
  parameter int SHIFT_W  = 4,
  parameter int SUB_RATE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CODE_W-1:0]  calCode,
  input  logic [CNT_W-1:0]   lowThresh,
  input  logic [CODE_W-1:0]  coarseStep,
  input  logic [SHIFT_W-1:0] relockShift,
  input  logic [CNT_W-1:0]   energyCount,
  input  logic               energyValid,
  output logic [CODE_W-1:0]  delayCode,
  output logic               invPol,
  output logic               locked
);
  dpStrobe_t st;
  logic      sweepEnd, belowBound;

  vib_phase_ctrl #(.SUB_RATE(SUB_RATE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .energyValid(energyValid),
    .sweepEnd(sweepEnd), .belowBound(belowBound), .invPol(invPol),
    .st(st), .locked(locked)
  );

  vib_phase_dp #(.CODE_W(CODE_W), .CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .calCode(calCode),
    .lowThresh(lowThresh), .coarseStep(coarseStep), .relockShift(relockShift),
    .energyCount(energyCount), .sweepEnd(sweepEnd), .belowBound(belowBound),
    .delayCode(delayCode), .invPol(invPol)
  );
endmodule

// File: tb/tb_vib_phase_seek.sv
module tb_vib_phase_seek;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  calCode = 8'd5;
  logic [15:0] lowThresh = 16'd10;
  logic [7:0]  coarseStep = 8'd2;
  logic [3:0]  relockShift = 4'd2;
  logic [15:0] energyCount = '0;
  logic        energyValid = 1'b0;
  logic [7:0]  delayCode;
  logic        invPol, locked;
  int          nChecks = 0, nFails = 0;

  always #10 clk = ~clk;

  vib_phase_seek dut (
    .clk(clk), .rst_n(rst_n), .start(start), .calCode(calCode),
    .lowThresh(lowThresh), .coarseStep(coarseStep), .relockShift(relockShift),
    .energyCount(energyCount), .energyValid(energyValid),
    .delayCode(delayCode), .invPol(invPol), .locked(locked)
  );

  // {count[15:0], expCode[7:0], expPol, expLocked}
  localparam int NV = 29;
  localparam logic [25:0] VEC [NV] = '{
    // first search, calCode 5, lowThresh 10, coarse 2, shift 2 (bound 3/4)
    {16'd5,   8'd2, 1'b0, 1'b0},  // R4 coarse step 0->2
    {16'd40,  8'd3, 1'b0, 1'b0},  // R4 unit step
    {16'd30,  8'd4, 1'b0, 1'b0},  // R6 local peak ignored
    {16'd40,  8'd5, 1'b0, 1'b0},  // R6 tie keeps code 2
    {16'd12,  8'd0, 1'b1, 1'b0},  // R2 R5 flip at calCode
    {16'd20,  8'd1, 1'b1, 1'b0},
    {16'd50,  8'd2, 1'b1, 1'b0},
    {16'd3,   8'd4, 1'b1, 1'b0},  // R4 coarse 2->4
    {16'd8,   8'd1, 1'b1, 1'b1},  // R3 R9 inverted 50 wins
    // locked, max 50, bound 38
    {16'd10,  8'd1, 1'b1, 1'b1},  // R7 not compared
    {16'd10,  8'd1, 1'b1, 1'b1},
    {16'd10,  8'd1, 1'b1, 1'b1},
    {16'd38,  8'd1, 1'b1, 1'b1},  // R8 equal to bound holds
    {16'd100, 8'd1, 1'b1, 1'b1},
    {16'd0,   8'd1, 1'b1, 1'b1},  // R7 zero ignored
    {16'd0,   8'd1, 1'b1, 1'b1},
    {16'd37,  8'd0, 1'b0, 1'b0},  // R8 below bound restarts
    // second search, tie between polarities
    {16'd30,  8'd1, 1'b0, 1'b0},
    {16'd10,  8'd2, 1'b0, 1'b0},
    {16'd10,  8'd3, 1'b0, 1'b0},
    {16'd10,  8'd4, 1'b0, 1'b0},
    {16'd10,  8'd5, 1'b0, 1'b0},
    {16'd10,  8'd0, 1'b1, 1'b0},  // R2
    {16'd10,  8'd1, 1'b1, 1'b0},
    {16'd30,  8'd2, 1'b1, 1'b0},
    {16'd10,  8'd3, 1'b1, 1'b0},
    {16'd10,  8'd4, 1'b1, 1'b0},
    {16'd10,  8'd5, 1'b1, 1'b0},
    {16'd10,  8'd0, 1'b0, 1'b1}   // R3 tie -> direct
  };

  task automatic check(input string req, input logic [7:0] expCode,
                       input logic expPol, input logic expLk);
    nChecks++;
    if (delayCode !== expCode || invPol !== expPol || locked !== expLk) begin
      nFails++;
      $display("FAIL %s: got code=%0d pol=%0b lk=%0b expected code=%0d pol=%0b lk=%0b",
               req, delayCode, invPol, locked, expCode, expPol, expLk);
    end
  endtask

  task automatic send(input logic [15:0] c);
    @(negedge clk);
    energyCount = c;
    energyValid = 1'b1;
    @(negedge clk);
    energyValid = 1'b0;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 8'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    send(16'd99);                         // R1 no search before start
    check("R1 idle ignores counts", 8'd0, 1'b0, 1'b0);
    pulseStart();
    check("R1 start", 8'd0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][25:10]);
      check($sformatf("R4/R6/R8 vector %0d", i), VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end

    // R10 restart while locked; calCode 0 gives one code per sweep
    calCode = 8'd0;
    pulseStart();
    check("R10 start while locked", 8'd0, 1'b0, 1'b0);
    send(16'd7);
    check("R5 calCode 0 flip", 8'd0, 1'b1, 1'b0);
    send(16'd9);
    check("R3 inverted larger", 8'd0, 1'b1, 1'b1);

    // R10 restart in the middle of a sweep
    calCode = 8'd5;
    pulseStart();
    send(16'd20);
    send(16'd20);
    check("R4 mid sweep", 8'd2, 1'b0, 1'b0);
    pulseStart();
    check("R10 start mid sweep", 8'd0, 1'b0, 1'b0);

    // R8 shift 0: bound is 0, so no count can drop the lock
    relockShift = 4'd0;
    calCode = 8'd0;
    send(16'd6);
    send(16'd4);
    check("R3 direct larger", 8'd0, 1'b0, 1'b1);
    for (int k = 0; k < 4; k++) send(16'd0);
    check("R8 zero bound holds", 8'd0, 1'b0, 1'b1);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule